// File: doc/BRIEF.md
# Byte-Oriented Serial Bus Target with Brownout Abort

This block is the bus-facing front end of a small register device on a two-wire serial bus in the I2C style. It samples the clock and data lines through synchronisers running on a faster system clock, and it detects start and stop conditions by comparing successive samples. After a start it matches a 7-bit device address. In a write it acknowledges every byte: the first data byte loads an 8-bit register pointer, and each later byte is stored at that pointer before the pointer advances. In a read it shifts out register contents MSB first for as long as the master acknowledges. Data is driven through an open-drain enable only.

An external low-voltage indication takes priority over all bus activity. While it is active, any transfer in progress ends at once, the data line is released, and no command is accepted. A stop condition returns the block to a standby state in which it waits for the next start. This includes the stop that closes a read.

Top module: `i2c_target_lvr`

## Requirements
- R1: After synchronous reset `sda_oe_o` is 0 and `standby_o` is 1.
- R2: In standby, clock pulses and data bits on the bus without a preceding start condition (SDA high-to-low while SCL high) get no acknowledge.
- R3: After a start, a first byte whose upper seven bits equal `DEV_ADDR` (bit 0 = 1 for read, 0 for write) is acknowledged by pulling SDA low in the ninth clock. Any other address gets no acknowledge, and the block ignores the bus until the next start.
- R4: In a write, every byte after the address is acknowledged. The first of these bytes loads the register pointer. Each later byte is stored at the pointer, and then the pointer increments by one.
- R5: In a read, the block sends the register at the pointer, MSB first, and releases SDA during the ninth clock. It then increments the pointer.
- R6: If the master acknowledges a read byte, the next register follows. On a not-acknowledge the block drives nothing more until a stop or start.
- R7: `standby_o` is 0 during an addressed transfer and returns to 1 after a stop condition (SDA low-to-high while SCL high), including a stop that ends a read.
- R8: A start condition is accepted in any state. A repeated start inside a transfer returns the block to address reception with the pointer kept.
- R9: While `lvr_i` is 1, `sda_oe_o` is 0 by the next clock, the transfer is abandoned, and a new start and matching address are not acknowledged.
- R10: The pointer is 8 bits wide and addresses register `pointer mod REG_DEPTH`. Pointer 0x10 therefore reaches register 0 when REG_DEPTH is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| lvr_i | input | 1 | Low-voltage indication, active high |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| standby_o | output | 1 | 1 while waiting for a start condition |

## Verification
The hardest case to reach is a low-voltage abort that lands while the block is itself pulling SDA low for an acknowledge. The bench therefore stops the master partway through an acknowledge cycle. It holds SCL low after the eighth bit of a write byte, confirms that the block is driving, and raises `lvr_i` before it completes the ninth clock. It then issues a full start and address while the input is still high, to show the lock-out. The pointer wrap is reached by writing at pointer 0x0F and reading on across the boundary.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // standby, waiting for a start
    ST_ADDR,   // receiving the address byte
    ST_AACK,   // driving the address acknowledge
    ST_WR,     // receiving a write byte
    ST_WACK,   // driving a write acknowledge
    ST_RD,     // shifting out a read byte
    ST_RACK,   // sampling the master's acknowledge
    ST_HOLD    // not driving, waiting for stop or start
  } tgt_state_e;

  typedef struct packed {
    logic scl_hi;
    logic scl_rise;
    logic scl_fall;
    logic sda;
    logic start;
    logic stop;
  } bus_ev_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync
  import i2c_tgt_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_s, sda_s, scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_comb begin
    ev.scl_hi   = scl_s;
    ev.scl_rise = scl_s & ~scl_q;
    ev.scl_fall = ~scl_s & scl_q;
    ev.sda      = sda_s;
    ev.start    = scl_s & scl_q & sda_q & ~sda_s;
    ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
  end

endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvr_i,
  input  bus_ev_t          ev,
  input  logic [7:0]       rd_data,
  output logic             we,
  output logic [IDX_W-1:0] waddr,
  output logic [7:0]       wdata,
  output logic [IDX_W-1:0] raddr,
  output logic             sda_oe,
  output logic             standby
);

  tgt_state_e state_q;
  logic [2:0] cnt_q;
  logic [7:0] sh_q;
  logic [7:0] ptr_q;
  logic       done_q, rw_q, first_q, mack_q;

  always_ff @(posedge clk) begin
    we <= 1'b0;
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      done_q  <= 1'b0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      mack_q  <= 1'b0;
      sda_oe  <= 1'b0;
      waddr   <= '0;
      wdata   <= '0;
    end else if (lvr_i) begin
      state_q <= ST_IDLE;
      sda_oe  <= 1'b0;
      done_q  <= 1'b0;
    end else if (ev.start) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (ev.stop) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WR: begin
          if (ev.scl_rise && !done_q) begin
            sh_q  <= {sh_q[6:0], ev.sda};
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) done_q <= 1'b1;
          end else if (ev.scl_fall && done_q) begin
            done_q <= 1'b0;
            cnt_q  <= '0;
            if (state_q == ST_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                state_q <= ST_AACK;
                sda_oe  <= 1'b1;
                rw_q    <= sh_q[0];
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              state_q <= ST_WACK;
              sda_oe  <= 1'b1;
              if (first_q) begin
                ptr_q   <= sh_q;
                first_q <= 1'b0;
              end else begin
                we    <= 1'b1;
                waddr <= ptr_q[IDX_W-1:0];
                wdata <= sh_q;
                ptr_q <= ptr_q + 8'd1;
              end
            end
          end
        end
        ST_AACK: begin
          if (ev.scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              state_q <= ST_RD;
              sh_q    <= rd_data;
              sda_oe  <= ~rd_data[7];
            end else begin
              state_q <= ST_WR;
              first_q <= 1'b1;
              sda_oe  <= 1'b0;
            end
          end
        end
        ST_WACK: begin
          if (ev.scl_fall) begin
            state_q <= ST_WR;
            sda_oe  <= 1'b0;
          end
        end
        ST_RD: begin
          if (ev.scl_fall) begin
            if (cnt_q == 3'd7) begin
              state_q <= ST_RACK;
              sda_oe  <= 1'b0;
              ptr_q   <= ptr_q + 8'd1;
            end else begin
              sh_q   <= {sh_q[6:0], 1'b0};
              sda_oe <= ~sh_q[6];
              cnt_q  <= cnt_q + 3'd1;
            end
          end
        end
        ST_RACK: begin
          if (ev.scl_rise) begin
            mack_q <= ~ev.sda;
          end else if (ev.scl_fall) begin
            cnt_q <= '0;
            if (mack_q) begin
              state_q <= ST_RD;
              sh_q    <= rd_data;
              sda_oe  <= ~rd_data[7];
            end else begin
              state_q <= ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign raddr   = ptr_q[IDX_W-1:0];
  assign standby = (state_q == ST_IDLE);

  // R9: a low-voltage indication releases the line by the next clock
  p_lvr_release_r9: assert property (@(posedge clk) disable iff (rst)
    lvr_i |=> !sda_oe);

  // R2 / R6: nothing is driven while waiting for a start or a stop
  p_quiet_wait_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE || state_q == ST_HOLD) |-> !sda_oe);

  // R3: the line is only taken low while the synchronised clock is low
  p_drive_scl_low_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(!ev.scl_hi));

  // R4: a register write coincides with entering the write acknowledge
  p_write_in_ack_r4: assert property (@(posedge clk) disable iff (rst)
    we |-> (state_q == ST_WACK && sda_oe));

endmodule

// File: rtl/i2c_target_lvr.sv
module i2c_target_lvr
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         REG_DEPTH   = 16,
  parameter int         SYNC_STAGES = 2,
  localparam int        IDX_W       = $clog2(REG_DEPTH)
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic lvr_i,
  output logic sda_oe_o,
  output logic standby_o
);

  bus_ev_t          ev;
  logic             we;
  logic [IDX_W-1:0] waddr, raddr;
  logic [7:0]       wdata, rdata;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev    (ev)
  );

  i2c_tgt_ctrl #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .lvr_i   (lvr_i),
    .ev      (ev),
    .rd_data (rdata),
    .we      (we),
    .waddr   (waddr),
    .wdata   (wdata),
    .raddr   (raddr),
    .sda_oe  (sda_oe_o),
    .standby (standby_o)
  );

  i2c_tgt_regs #(.DEPTH(REG_DEPTH)) u_regs (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

endmodule

// File: tb/i2c_target_lvr_tb.sv
module i2c_target_lvr_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_WR = 8'hA0;
  localparam logic [7:0] A_RD = 8'hA1;

  typedef struct packed {
    logic [7:0] ptr;
    logic [7:0] d0;
    logic [7:0] d1;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{ptr: 8'h02, d0: 8'hA5, d1: 8'h3C},
    '{ptr: 8'h07, d0: 8'h00, d1: 8'hFF},
    '{ptr: 8'h0A, d0: 8'h81, d1: 8'h7E},
    '{ptr: 8'h04, d0: 8'h5A, d1: 8'hC3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic lvr = 1'b0;
  logic sda_oe, standby;
  logic sda_bus;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 0;

  assign sda_bus = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_target_lvr u_dut (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (m_scl),
    .sda_i     (sda_bus),
    .lvr_i     (lvr),
    .sda_oe_o  (sda_oe),
    .standby_o (standby)
  );

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_scl = 1'b0; wt(5);
    m_sda = 1'b1; wt(5);
    m_scl = 1'b1; wt(5);
    m_sda = 1'b0; wt(5);
  endtask

  task automatic bus_stop();
    m_scl = 1'b0; wt(5);
    m_sda = 1'b0; wt(5);
    m_scl = 1'b1; wt(5);
    m_sda = 1'b1; wt(10);
  endtask

  task automatic send8(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_scl = 1'b0; wt(5);
      m_sda = b[i]; wt(5);
      m_scl = 1'b1; wt(10);
    end
  endtask

  task automatic get_ack(output logic a);
    m_scl = 1'b0; wt(5);
    m_sda = 1'b1; wt(5);
    m_scl = 1'b1; wt(5);
    a = ~sda_bus; wt(5);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    send8(b);
    get_ack(a);
  endtask

  task automatic read_byte(output logic [7:0] b, input logic give_ack, output logic rel);
    for (int i = 7; i >= 0; i--) begin
      m_scl = 1'b0; wt(5);
      m_sda = 1'b1; wt(5);
      m_scl = 1'b1; wt(5);
      b[i] = sda_bus; wt(5);
    end
    m_scl = 1'b0; wt(5);
    rel = ~sda_oe;
    m_sda = give_ack ? 1'b0 : 1'b1; wt(5);
    m_scl = 1'b1; wt(5);
    rel = rel & ~sda_oe; wt(5);
  endtask

  initial begin
    logic a, rel;
    logic [7:0] b;

    wt(5);
    rst = 1'b0;
    wt(2);
    // R1: reset state
    chk("R1 oe", {7'd0, sda_oe}, 8'h00);
    chk("R1 standby", {7'd0, standby}, 8'h01);

    // R2: a byte with no start is ignored
    send_byte(A_WR, a);
    chk("R2 no ack without start", {7'd0, a}, 8'h00);
    bus_stop();

    // R3: wrong address is not acknowledged, following bits ignored
    bus_start();
    send_byte(8'hA2, a);
    chk("R3 mismatch nack", {7'd0, a}, 8'h00);
    chk("R3 idle after mismatch", {7'd0, standby}, 8'h01);
    send_byte(8'h00, a);
    chk("R3 ignored after mismatch", {7'd0, a}, 8'h00);
    bus_stop();

    // Table: write two bytes, then read back across repeated starts
    foreach (VECS[k]) begin
      bus_start();
      send_byte(A_WR, a);
      chk("R3 address ack", {7'd0, a}, 8'h01);
      chk("R7 busy in transfer", {7'd0, standby}, 8'h00);
      send_byte(VECS[k].ptr, a); chk("R4 pointer ack", {7'd0, a}, 8'h01);
      send_byte(VECS[k].d0, a);  chk("R4 data0 ack", {7'd0, a}, 8'h01);
      send_byte(VECS[k].d1, a);  chk("R4 data1 ack", {7'd0, a}, 8'h01);
      bus_start();
      send_byte(A_WR, a);
      send_byte(VECS[k].ptr, a);
      bus_start();
      send_byte(A_RD, a);
      chk("R8 repeated start read ack", {7'd0, a}, 8'h01);
      read_byte(b, 1'b1, rel);
      chk("R5 read data0", b, VECS[k].d0);
      chk("R5 release in ninth clock", {7'd0, rel}, 8'h01);
      read_byte(b, 1'b0, rel);
      chk("R6 read next after ack", b, VECS[k].d1);
      bus_stop();
      chk("R7 standby after read stop", {7'd0, standby}, 8'h01);
    end

    // R6: after a NACK nothing more is driven
    bus_start();
    send_byte(A_WR, a);
    send_byte(8'h02, a);
    bus_start();
    send_byte(A_RD, a);
    read_byte(b, 1'b0, rel);
    chk("R6 byte before nack", b, 8'hA5);
    read_byte(b, 1'b1, rel);
    chk("R6 silent after nack", b, 8'hFF);
    chk("R6 not busy driving", {7'd0, rel}, 8'h01);
    bus_stop();

    // R10: pointer 0x10 reaches register 0
    bus_start();
    send_byte(A_WR, a);
    send_byte(8'h0F, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    bus_start();
    send_byte(A_WR, a);
    send_byte(8'h0F, a);
    bus_start();
    send_byte(A_RD, a);
    read_byte(b, 1'b1, rel);
    chk("R10 last register", b, 8'h11);
    read_byte(b, 1'b0, rel);
    chk("R10 wrapped register", b, 8'h22);
    bus_stop();

    // R9: abort while the block drives an acknowledge
    bus_start();
    send_byte(A_WR, a);
    send8(8'h03);
    m_scl = 1'b0; wt(6);
    chk("R9 driving ack before abort", {7'd0, sda_oe}, 8'h01);
    lvr = 1'b1; wt(2);
    chk("R9 released on lvr", {7'd0, sda_oe}, 8'h00);
    chk("R9 standby on lvr", {7'd0, standby}, 8'h01);
    m_sda = 1'b1; wt(5);
    m_scl = 1'b1; wt(5);
    bus_start();
    send_byte(A_WR, a);
    chk("R9 lockout of new command", {7'd0, a}, 8'h00);
    bus_stop();
    lvr = 1'b0; wt(3);
    bus_start();
    send_byte(A_WR, a);
    chk("R9 recovers after lvr", {7'd0, a}, 8'h01);
    bus_stop();
    chk("R7 standby after write stop", {7'd0, standby}, 8'h01);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule